// File: doc/BRIEF.md
# Link Qualification Hysteresis Monitor

This block decides when a receive link may be trusted. A signal-detect input shows that line energy is present. Its rising edge does not bring the link up at once. The machine first waits in a qualification state while a down-counter steps through a fixed number of time steps. If signal detect stays high until the count has run out, the link is declared up. If signal detect drops at any time, the machine goes back to the down state. The counter is reloaded, so the next attempt again waits the whole interval. A count left part-way through is never resumed.

The time base comes from a one-cycle pulse, `tick_i`, that is generated outside the block; by default it is one pulse per microsecond. The counter takes one step for every `TICK_DIV` tick pulses counted while the machine is qualifying, and it must take `LOAD_VAL` steps to run out. The current state is brought out for debug, and a separate link-ready output is provided for the logic that consumes link status.

Top module: `link_hyst_mon`

## Requirements
- R1: While reset is asserted and after it is released, the machine is in the down state (`state_o` = 0), `link_up_o` is 0, and the counter holds its full load value.
- R2: In the down state, a clock edge that samples `sig_det_i` high moves the machine to the qualifying state (`state_o` = 1).
- R3: While qualifying, the counter takes one step for every `TICK_DIV` tick pulses. The pulse count starts from zero each time the machine enters the qualifying state, and the counter never moves by more than one per cycle.
- R4: With `sig_det_i` held high, the machine enters the up state (`state_o` = 2) on the clock edge after the counter reaches zero. That zero is reached after `LOAD_VAL` steps.
- R5: In the qualifying state, a clock edge that samples `sig_det_i` low returns the machine to the down state, and `link_up_o` stays 0.
- R6: Each entry into the qualifying state starts from the full load value, so an attempt that follows an aborted one waits the whole `LOAD_VAL` steps again.
- R7: In the up state, a clock edge that samples `sig_det_i` low returns the machine to the down state and clears `link_up_o`.
- R8: `link_up_o` is 1 exactly when `state_o` is 2, and `state_o` never takes the value 3.
- R9: With no tick pulses, the machine stays in the qualifying state for as long as `sig_det_i` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_det_i | input | 1 | Line signal detect, synchronous to clk_i |
| tick_i | input | 1 | One-cycle time-base pulse (nominally 1 µs) |
| link_up_o | output | 1 | Link qualified and up |
| state_o | output | 2 | Current state: 0 down, 1 qualifying, 2 up |

## Verification
The bench builds the block with `LOAD_VAL` = 5 and `TICK_DIV` = 3, so one full qualification takes 15 tick pulses. With counts this small, the bench can drive many complete qualifications, aborted attempts at different depths, and the re-entry that must not resume a partial count. Using a divide ratio above one also exercises the pulse prescaler and its restart on every entry. A per-cycle reference model checks both outputs against steady ticks, sparse ticks, no ticks and random signal-detect activity.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  typedef enum logic [1:0] {
    LS_DOWN = 2'd0,
    LS_HYST = 2'd1,
    LS_UP   = 2'd2
  } link_st_e;
endpackage

// File: rtl/lhm_step_gen.sv
module lhm_step_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic step_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign step_o = run_i & tick_i;
    end else begin : g_div
      localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         pre_q <= '0;
        else if (!run_i)     pre_q <= '0;   // restart on every entry
        else if (tick_i)     pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
      end

      assign step_o = run_i & tick_i & (pre_q == PRE_MAX);
    end
  endgenerate
endmodule

// File: rtl/lhm_hold_timer.sv
module lhm_hold_timer #(
  parameter int LOAD_VAL = 500,
  parameter int CNT_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOAD_VAL);
  logic [CNT_W-1:0] cnt_q;

  // reload whenever not qualifying: no partial count survives an exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= LOAD;
    else if (!run_i)                 cnt_q <= LOAD;
    else if (step_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lhm_fsm.sv
module lhm_fsm
  import lhm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sig_det_i,
  input  logic     done_i,
  output link_st_e state_o,
  output logic     run_o
);
  link_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LS_DOWN: if (sig_det_i) st_d = LS_HYST;
      LS_HYST: begin
        if (!sig_det_i)   st_d = LS_DOWN;
        else if (done_i)  st_d = LS_UP;
      end
      LS_UP:   if (!sig_det_i) st_d = LS_DOWN;
      default: st_d = LS_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LS_DOWN;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign run_o   = (st_q == LS_HYST);
endmodule

// File: rtl/link_hyst_mon.sv
module link_hyst_mon
  import lhm_pkg::*;
#(
  parameter int LOAD_VAL = 500,
  parameter int TICK_DIV = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_det_i,
  input  logic       tick_i,
  output logic       link_up_o,
  output logic [1:0] state_o
);
  localparam int CNT_W = $clog2(LOAD_VAL + 1);

  link_st_e         st;
  logic             run, step, done;
  logic [CNT_W-1:0] hold_cnt;

  lhm_step_gen #(.TICK_DIV(TICK_DIV)) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick_i),
    .step_o(step)
  );

  lhm_hold_timer #(.LOAD_VAL(LOAD_VAL), .CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .step_i(step),
    .cnt_o (hold_cnt),
    .done_o(done)
  );

  lhm_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sig_det_i(sig_det_i),
    .done_i   (done),
    .state_o  (st),
    .run_o    (run)
  );

  assign state_o   = st;
  assign link_up_o = (st == LS_UP);
endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
  parameter int LOAD_VAL = 500,
  parameter int CNT_W    = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sig_det_i,
  input logic             link_up_o,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOAD_VAL);

  AST_DOWN_TO_HYST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && sig_det_i) |=> (state_o == 2'd1)); // R2

  AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && $past(state_o) == 2'd1) |->
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - CNT_W'(1))); // R3

  AST_UP_FROM_HYST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> ($past(state_o) == 2'd1)); // R4

  AST_HYST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !sig_det_i) |=> (state_o == 2'd0 && !link_up_o)); // R5

  AST_FULL_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && $past(state_o) != 2'd1) |-> (cnt_i == LOAD)); // R6

  AST_UP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && !sig_det_i) |=> (state_o == 2'd0 && !link_up_o)); // R7

  AST_NO_BAD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3); // R8
endmodule

bind link_hyst_mon lhm_checker #(.LOAD_VAL(LOAD_VAL), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sig_det_i(sig_det_i),
  .link_up_o(link_up_o),
  .state_o  (state_o),
  .cnt_i    (hold_cnt)
);

// File: tb/tb_link_hyst_mon.sv
module tb_link_hyst_mon;
  localparam int L = 5;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_det = 1'b0;
  logic       tick = 1'b0;
  logic       link_up;
  logic [1:0] state;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  typedef struct {
    int    st;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // reference model state
  int m_st = 0;
  int m_cnt = L;
  int m_pre = 0;

  always #4 clk = ~clk;

  link_hyst_mon #(.LOAD_VAL(L), .TICK_DIV(D)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sig_det_i(sig_det),
    .tick_i   (tick),
    .link_up_o(link_up),
    .state_o  (state)
  );

  task automatic check(input string tag, input int act_st, input int act_lu, input int exp_st);
    int exp_lu;
    exp_lu = (exp_st == 2) ? 1 : 0;
    checks++;
    if (act_st != exp_st || act_lu != exp_lu) begin
      errors++;
      $display("FAIL %s: state=%0d link_up=%0d expected state=%0d link_up=%0d",
               tag, act_st, act_lu, exp_st, exp_lu);
    end
  endtask

  // driver: drives one cycle and pushes the predicted outcome
  task automatic step(input logic sd, input logic tk, input string tag);
    int ns;
    exp_t e;
    @(negedge clk);
    sig_det = sd;
    tick    = tk;
    case (m_st)
      0:       ns = sd ? 1 : 0;
      1:       ns = !sd ? 0 : ((m_cnt == 0) ? 2 : 1);
      default: ns = sd ? 2 : 0;
    endcase
    if (m_st != 1) begin
      m_cnt = L;
      m_pre = 0;
    end else if (tk) begin
      if (m_pre == D - 1) begin
        m_pre = 0;
        if (m_cnt != 0) m_cnt--;
      end else m_pre++;
    end
    m_st  = ns;
    e.st  = ns;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, int'(state), int'(link_up), e.st);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(state), int'(link_up), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 after reset", int'(state), int'(link_up), 0);

    // idle, then qualify with a tick every cycle
    repeat (3) step(1'b0, 1'b1, "R1 idle");
    step(1'b1, 1'b1, "R2 entry");
    repeat (L * D + 4) step(1'b1, 1'b1, "R4 full qualify");
    step(1'b0, 1'b0, "R7 drop from up");
    step(1'b0, 1'b1, "R7 stay down");

    // abort part-way, then re-enter and wait the full interval
    step(1'b1, 1'b0, "R2 entry");
    repeat (3 * D) step(1'b1, 1'b1, "R3 partial");
    step(1'b0, 1'b1, "R5 abort");
    step(1'b1, 1'b1, "R6 re-entry");
    repeat (L * D + 3) step(1'b1, 1'b1, "R6 full wait");
    step(1'b0, 1'b0, "R7 drop");

    // abort one step before expiry
    step(1'b1, 1'b0, "R2 entry");
    repeat ((L - 1) * D + 2) step(1'b1, 1'b1, "R3 near expiry");
    step(1'b0, 1'b0, "R5 late abort");
    step(1'b1, 1'b0, "R6 re-entry");
    repeat (L * D + 2) step(1'b1, 1'b1, "R6 full wait again");

    // no ticks: hold in qualification
    step(1'b0, 1'b0, "R7 drop");
    step(1'b1, 1'b0, "R2 entry");
    repeat (40) step(1'b1, 1'b0, "R9 no tick");
    for (int i = 0; i < 60; i++) step(1'b1, (i % 4) == 0, "R3 sparse tick");

    // random activity
    for (int i = 0; i < 400; i++) begin
      logic sd_r, tk_r;
      sd_r = (($urandom % 16) != 0);
      tk_r = (($urandom % 3) != 0);
      step(sd_r, tk_r, "R8 random");
    end

    @(negedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule